// File: doc/BRIEF.md
# Software-Refilled Address Translation Unit

This unit translates addresses for a small 32-bit soft processor. It has one lookup port for instruction fetches and one for data accesses. Each port maps a virtual page number to a physical page number through a small fully associative table. Only software writes that table. The unit never walks page tables in memory. A lookup that finds no entry raises a miss, and the exception handler must load an entry and return.

Translation depends on the privilege level. In kernel mode translation is off and addresses pass straight through. In user mode every request goes through the table, and an entry can be marked as reserved for kernel use. An exception-entry strobe forces kernel mode and copies the mode that was active into a one-level saved-mode register. An exception-return strobe restores that saved mode. Software can preload the saved mode, and this is how it enters user mode for the first time.

Top module: `xlat_unit`

## Requirements
- R1: After reset the unit is in kernel mode (`userMode` = 0), and a request returns its own address on the physical-address output with no miss and no fault.
- R2: In kernel mode both ports pass the address through unchanged and never assert miss or fault, whatever the table holds.
- R3: In user mode a request that hits a valid entry whose kernel-only bit is 0 returns {entry physical page number, request address bits 11:0}, with miss and fault both low.
- R4: In user mode a request whose upper 20 address bits match no valid entry asserts the miss output of that port only. The miss stays high on every cycle while the request is held, and it drops after the clock edge that samples `excEnter`. A port whose request is low asserts neither miss nor fault.
- R5: In user mode a request that hits an entry with the kernel-only bit set asserts the fault output of that port and not its miss output.
- R6: A clock edge that samples `excEnter` sets kernel mode and stores the previous mode in the saved-mode register. A clock edge that samples `excReturn` (without `excEnter`) loads the mode from the saved-mode register.
- R7: An exception taken while already in kernel mode stores kernel mode, so the following return stays in kernel mode.
- R8: A clock edge with `wrEn` high loads entry `wrIdx` with a valid bit, `wrVpn`, `wrPpn` and `wrKern`, replacing the previous contents. The new entry is used by lookups from the next cycle on.
- R9: A clock edge with `flushAll` high clears the valid bit of every entry. A write in the same cycle is dropped.
- R10: When several valid entries match the same virtual page, the entry with the lowest index supplies the translation.
- R11: A clock edge with `savedModeWr` high loads `savedModeVal` into the saved-mode register (1 = user), so a later return enters that mode. `excEnter` takes precedence over both `excReturn` and `savedModeWr` in the same cycle. A return in the same cycle as a saved-mode write uses the old saved mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| iReq | input | 1 | Instruction lookup request |
| iVaddr | input | 32 | Instruction virtual address |
| iPaddr | output | 32 | Instruction physical address |
| iMiss | output | 1 | Instruction table miss |
| iFault | output | 1 | Instruction kernel-only access from user mode |
| dReq | input | 1 | Data lookup request |
| dVaddr | input | 32 | Data virtual address |
| dPaddr | output | 32 | Data physical address |
| dMiss | output | 1 | Data table miss |
| dFault | output | 1 | Data kernel-only access from user mode |
| wrEn | input | 1 | Load one table entry |
| wrIdx | input | 3 | Index of the entry to load |
| wrVpn | input | 20 | Virtual page number to store |
| wrPpn | input | 20 | Physical page number to store |
| wrKern | input | 1 | Kernel-only bit to store |
| flushAll | input | 1 | Invalidate every entry |
| excEnter | input | 1 | Exception or interrupt taken |
| excReturn | input | 1 | Return from exception |
| savedModeWr | input | 1 | Load the saved-mode register |
| savedModeVal | input | 1 | Value for the saved mode (1 = user) |
| userMode | output | 1 | Current mode, 1 = user with translation on |

## Verification
The assertions assume that the mode strobes and table commands are single-cycle pulses sampled on the rising edge, and that the request addresses are stable during the combinational window in which the outputs are read. Exception entry and exit are assumed to come from the core's own sequencing, so a return is normally never issued without a preceding entry or saved-mode write. The stimulus follows these rules. It drives every input just after a falling edge and holds it for a whole cycle. It raises entry and return together in only one directed case, which checks the precedence rule. Requests are held for several cycles only where the bench checks that a miss persists.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Strobes passed from the mode control to the translation datapath
  typedef struct packed {
    logic xlatOn;   // user mode: lookups translate through the table
    logic flush;    // invalidate every entry this cycle
    logic wrEn;     // load the addressed entry this cycle (already gated by flush)
  } tlbCtl_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    excEnter,
  input  logic    excReturn,
  input  logic    savedModeWr,
  input  logic    savedModeVal,
  input  logic    wrEn,
  input  logic    flushAll,
  output tlbCtl_t ctl,
  output logic    userMode
);
  logic savedMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      userMode  <= 1'b0;
      savedMode <= 1'b0;
    end else if (excEnter) begin
      savedMode <= userMode;
      userMode  <= 1'b0;
    end else begin
      if (excReturn)   userMode  <= savedMode;
      if (savedModeWr) savedMode <= savedModeVal;
    end
  end

  always_comb begin
    ctl.xlatOn = userMode;
    ctl.flush  = flushAll;
    ctl.wrEn   = wrEn & ~flushAll;
  end

  // R6: entry always lands in kernel mode
  p_enter_kernel_r6: assert property (@(posedge clk) disable iff (!rstN)
    excEnter |=> !userMode);
  // R6: return restores the saved mode
  p_return_restore_r6: assert property (@(posedge clk) disable iff (!rstN)
    (excReturn && !excEnter) |=> userMode == $past(savedMode));
  // R7: a nested entry from kernel records kernel
  p_nested_kernel_r7: assert property (@(posedge clk) disable iff (!rstN)
    (excEnter && !userMode) |=> !savedMode);
  // R11: entry wins over a saved-mode write in the same cycle
  p_enter_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (excEnter && savedModeWr) |=> savedMode == $past(userMode));
endmodule

// File: rtl/xlat_table.sv
module xlat_table
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  tlbCtl_t                         ctl,
  input  logic [IDX_W-1:0]                wrIdx,
  input  logic [VPN_W-1:0]                wrVpn,
  input  logic [VPN_W-1:0]                wrPpn,
  input  logic                            wrKern,
  output logic [ENTRIES-1:0]              validVec,
  output logic [ENTRIES-1:0][VPN_W-1:0]   vpnVec,
  output logic [ENTRIES-1:0][VPN_W-1:0]   ppnVec,
  output logic [ENTRIES-1:0]              kernVec
);
  always_ff @(posedge clk) begin
    if (!rstN)          validVec <= '0;
    else if (ctl.flush) validVec <= '0;
    else if (ctl.wrEn)  validVec[wrIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ctl.wrEn) begin
      vpnVec[wrIdx]  <= wrVpn;
      ppnVec[wrIdx]  <= wrPpn;
      kernVec[wrIdx] <= wrKern;
    end
  end

  // R9: flush leaves no valid entry behind
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> validVec == '0);
  // R8: a written entry is valid on the next cycle
  p_write_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |=> validVec[$past(wrIdx)]);
endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  localparam int VPN_W  = VA_W - OFF_W
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  tlbCtl_t                         ctl,
  input  logic                            req,
  input  logic [VA_W-1:0]                 vaddr,
  input  logic [ENTRIES-1:0]              validVec,
  input  logic [ENTRIES-1:0][VPN_W-1:0]   vpnVec,
  input  logic [ENTRIES-1:0][VPN_W-1:0]   ppnVec,
  input  logic [ENTRIES-1:0]              kernVec,
  output logic [VA_W-1:0]                 paddr,
  output logic                            miss,
  output logic                            fault
);
  logic             hit;
  logic [VPN_W-1:0] selPpn;
  logic             selKern;

  // Scan from the top down so the lowest matching index is the last writer
  always_comb begin
    hit     = 1'b0;
    selPpn  = '0;
    selKern = 1'b0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (validVec[k] && vpnVec[k] == vaddr[VA_W-1:OFF_W]) begin
        hit     = 1'b1;
        selPpn  = ppnVec[k];
        selKern = kernVec[k];
      end
    end
  end

  always_comb begin
    paddr = ctl.xlatOn ? {selPpn, vaddr[OFF_W-1:0]} : vaddr;
    miss  = req & ctl.xlatOn & ~hit;
    fault = req & ctl.xlatOn & hit & selKern;
  end

  // R5: one request never reports both a miss and a fault
  p_miss_fault_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(miss && fault));
  // R2: kernel mode reports nothing
  p_kernel_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.xlatOn |-> (!miss && !fault));
  // R3: the page offset is never altered
  p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    paddr[OFF_W-1:0] == vaddr[OFF_W-1:0]);
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             iReq,
  input  logic [VA_W-1:0]  iVaddr,
  output logic [VA_W-1:0]  iPaddr,
  output logic             iMiss,
  output logic             iFault,
  input  logic             dReq,
  input  logic [VA_W-1:0]  dVaddr,
  output logic [VA_W-1:0]  dPaddr,
  output logic             dMiss,
  output logic             dFault,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [VPN_W-1:0] wrPpn,
  input  logic             wrKern,
  input  logic             flushAll,
  input  logic             excEnter,
  input  logic             excReturn,
  input  logic             savedModeWr,
  input  logic             savedModeVal,
  output logic             userMode
);
  localparam int PORTS = 2;

  tlbCtl_t                       ctl;
  logic [ENTRIES-1:0]            validVec;
  logic [ENTRIES-1:0][VPN_W-1:0] vpnVec;
  logic [ENTRIES-1:0][VPN_W-1:0] ppnVec;
  logic [ENTRIES-1:0]            kernVec;

  logic [PORTS-1:0]            reqA;
  logic [PORTS-1:0][VA_W-1:0]  vaddrA;
  logic [PORTS-1:0][VA_W-1:0]  paddrA;
  logic [PORTS-1:0]            missA;
  logic [PORTS-1:0]            faultA;

  assign reqA   = {dReq, iReq};
  assign vaddrA = {dVaddr, iVaddr};
  assign iPaddr = paddrA[0];
  assign dPaddr = paddrA[1];
  assign iMiss  = missA[0];
  assign dMiss  = missA[1];
  assign iFault = faultA[0];
  assign dFault = faultA[1];

  xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .excEnter(excEnter), .excReturn(excReturn),
    .savedModeWr(savedModeWr), .savedModeVal(savedModeVal),
    .wrEn(wrEn), .flushAll(flushAll), .ctl(ctl), .userMode(userMode)
  );

  xlat_table #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_table (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrIdx(wrIdx), .wrVpn(wrVpn),
    .wrPpn(wrPpn), .wrKern(wrKern), .validVec(validVec), .vpnVec(vpnVec),
    .ppnVec(ppnVec), .kernVec(kernVec)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    xlat_lookup #(.ENTRIES(ENTRIES), .VA_W(VA_W), .OFF_W(OFF_W)) u_lookup (
      .clk(clk), .rstN(rstN), .ctl(ctl), .req(reqA[p]), .vaddr(vaddrA[p]),
      .validVec(validVec), .vpnVec(vpnVec), .ppnVec(ppnVec), .kernVec(kernVec),
      .paddr(paddrA[p]), .miss(missA[p]), .fault(faultA[p])
    );
  end

  // R4: a miss on one port never shows up on the other when it is idle
  p_idle_port_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!iReq |-> (!iMiss && !iFault)) and (!dReq |-> (!dMiss && !dFault)));
endmodule

// File: tb/xlat_unit_tb.sv
module xlat_unit_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        iReq, dReq;
  logic [31:0] iVaddr, dVaddr, iPaddr, dPaddr;
  logic        iMiss, iFault, dMiss, dFault;
  logic        wrEn, wrKern, flushAll, excEnter, excReturn, savedModeWr, savedModeVal;
  logic [2:0]  wrIdx;
  logic [19:0] wrVpn, wrPpn;
  logic        userMode;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  xlat_unit u_dut (
    .clk(clk), .rstN(rstN),
    .iReq(iReq), .iVaddr(iVaddr), .iPaddr(iPaddr), .iMiss(iMiss), .iFault(iFault),
    .dReq(dReq), .dVaddr(dVaddr), .dPaddr(dPaddr), .dMiss(dMiss), .dFault(dFault),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrVpn(wrVpn), .wrPpn(wrPpn), .wrKern(wrKern),
    .flushAll(flushAll), .excEnter(excEnter), .excReturn(excReturn),
    .savedModeWr(savedModeWr), .savedModeVal(savedModeVal), .userMode(userMode)
  );

  // {isData, vaddr, expected paddr, expected miss, expected fault}, user mode
  localparam logic [66:0] VEC [8] = '{
    {1'b0, 32'h0001_0ABC, 32'h8001_0ABC, 1'b0, 1'b0},
    {1'b1, 32'h0001_0FFF, 32'h8001_0FFF, 1'b0, 1'b0},
    {1'b0, 32'h0002_0123, 32'h0000_0000, 1'b0, 1'b1},
    {1'b1, 32'h0003_0004, 32'hA003_0004, 1'b0, 1'b0},
    {1'b0, 32'h0004_0000, 32'h0000_0000, 1'b1, 1'b0},
    {1'b1, 32'hFFFF_F800, 32'h0000_1800, 1'b0, 1'b0},
    {1'b1, 32'h0005_0000, 32'h0000_0000, 1'b1, 1'b0},
    {1'b0, 32'hFFFF_F000, 32'h0000_1000, 1'b0, 1'b0}
  };

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [19:0] vpn, input logic [19:0] ppn, input logic kern);
    wrEn = 1; wrIdx = idx; wrVpn = vpn; wrPpn = ppn; wrKern = kern;
    tick();
    wrEn = 0;
  endtask

  task automatic pulseEnter();
    excEnter = 1; tick(); excEnter = 0;
  endtask

  task automatic pulseReturn();
    excReturn = 1; tick(); excReturn = 0;
  endtask

  task automatic lookI(input logic [31:0] va);
    iReq = 1; dReq = 0; iVaddr = va; #1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 0; iReq = 0; dReq = 0; iVaddr = '0; dVaddr = '0;
    wrEn = 0; wrIdx = '0; wrVpn = '0; wrPpn = '0; wrKern = 0; flushAll = 0;
    excEnter = 0; excReturn = 0; savedModeWr = 0; savedModeVal = 0;
    tick(); tick(); tick();
    rstN = 1;

    // R1: reset state
    chk(userMode == 1'b0, "R1 mode", {31'd0, userMode}, 32'd0);
    lookI(32'h1234_5678);
    chk(iPaddr == 32'h1234_5678 && !iMiss && !iFault, "R1 passthrough", iPaddr, 32'h1234_5678);
    iReq = 0;

    wr(3'd0, 20'h00010, 20'h80010, 1'b0);
    wr(3'd1, 20'h00020, 20'h80020, 1'b1);
    wr(3'd2, 20'h00030, 20'hA0030, 1'b0);
    wr(3'd5, 20'h00030, 20'hB0030, 1'b0);
    wr(3'd7, 20'hFFFFF, 20'h00001, 1'b0);

    // R2: kernel mode ignores the table
    iReq = 1; iVaddr = 32'h0004_0000; dReq = 1; dVaddr = 32'h0002_0123; #1;
    chk(iPaddr == iVaddr && !iMiss && !iFault, "R2 ifetch", iPaddr, iVaddr);
    chk(dPaddr == dVaddr && !dMiss && !dFault, "R2 data", dPaddr, dVaddr);
    iReq = 0; dReq = 0;

    // R11: preload saved mode, then return into user mode
    savedModeWr = 1; savedModeVal = 1; tick(); savedModeWr = 0;
    pulseReturn();
    chk(userMode == 1'b1, "R11 enter user", {31'd0, userMode}, 32'd1);

    // R3 R4 R5: table-driven lookups
    for (int v = 0; v < 8; v++) begin
      logic isD, em, ef;
      logic [31:0] va, pa, gotPa;
      logic gotM, gotF, othM, othF;
      string tag;
      {isD, va, pa, em, ef} = VEC[v];
      iReq = !isD; dReq = isD; iVaddr = va; dVaddr = va; #1;
      gotPa = isD ? dPaddr : iPaddr;
      gotM  = isD ? dMiss  : iMiss;
      gotF  = isD ? dFault : iFault;
      othM  = isD ? iMiss  : dMiss;
      othF  = isD ? iFault : dFault;
      tag = em ? "R4 vector miss" : (ef ? "R5 vector fault" : "R3 vector hit");
      chk(gotM == em && gotF == ef && !othM && !othF && (em || ef || gotPa == pa),
          tag, gotPa, pa);
      @(negedge clk);
    end
    iReq = 0; dReq = 0;

    // R10: duplicate page, lowest index wins
    dReq = 1; dVaddr = 32'h0003_0ABC; #1;
    chk(dPaddr == 32'hA003_0ABC && !dMiss, "R10 priority", dPaddr, 32'hA003_0ABC);
    dReq = 0;

    // R4: miss persists while held, cleared by exception entry
    lookI(32'h0004_0000);
    for (int c = 0; c < 3; c++) begin
      chk(iMiss == 1'b1, "R4 held miss", {31'd0, iMiss}, 32'd1);
      tick();
    end
    pulseEnter();
    chk(iMiss == 1'b0 && userMode == 1'b0, "R4 cleared by entry", {30'd0, userMode, iMiss}, 32'd0);
    iReq = 0;

    // R7: nested entry in kernel returns to kernel
    pulseEnter();
    pulseReturn();
    chk(userMode == 1'b0, "R7 nested return", {31'd0, userMode}, 32'd0);
    savedModeWr = 1; savedModeVal = 1; tick(); savedModeWr = 0;
    pulseReturn();
    chk(userMode == 1'b1, "R6 restore user", {31'd0, userMode}, 32'd1);

    // R8: overwrite and new entry
    wr(3'd0, 20'h00010, 20'h12345, 1'b0);
    lookI(32'h0001_0456);
    chk(iPaddr == 32'h1234_5456 && !iMiss, "R8 overwrite", iPaddr, 32'h1234_5456);
    iReq = 0;
    wr(3'd3, 20'h00060, 20'h00777, 1'b0);
    lookI(32'h0006_0010);
    chk(iPaddr == 32'h0077_7010 && !iMiss, "R8 new entry", iPaddr, 32'h0077_7010);
    iReq = 0;

    // R9: flush wins over a same-cycle write
    flushAll = 1; wrEn = 1; wrIdx = 3'd4; wrVpn = 20'h00070; wrPpn = 20'h00070; wrKern = 0;
    tick();
    flushAll = 0; wrEn = 0;
    lookI(32'h0001_0000);
    chk(iMiss == 1'b1, "R9 old entry gone", {31'd0, iMiss}, 32'd1);
    lookI(32'h0007_0000);
    chk(iMiss == 1'b1, "R9 write dropped", {31'd0, iMiss}, 32'd1);
    lookI(32'h0006_0000);
    chk(iMiss == 1'b1, "R9 recent entry gone", {31'd0, iMiss}, 32'd1);
    iReq = 0;

    // R11: entry beats return in the same cycle
    excEnter = 1; excReturn = 1; tick(); excEnter = 0; excReturn = 0;
    chk(userMode == 1'b0, "R11 entry precedence", {31'd0, userMode}, 32'd0);
    pulseReturn();
    chk(userMode == 1'b1, "R6 return after precedence", {31'd0, userMode}, 32'd1);

    done = 1;
    summary();
    $finish;
  end
endmodule